// File: doc/BRIEF.md
# Front-End Buffer Occupancy Emulator

This block predicts how full the event buffers of the remote front-end readout chips are, using only the first-level trigger stream. Each accepted trigger adds one pending event. An internal readout engine removes one event every `readout_len` clock cycles while anything is pending. The predicted occupancy drives local busy, warning, ready and error lines. Because these lines come straight from registers, the trigger controller can slow or stop triggers before the real buffers overflow. The feedback reaches it well inside the 75 ns budget.

The capacity depends on the operating mode. Peak mode holds 31 pending events. Deconvolution mode takes three samples per trigger, so it holds only 10. The local status is merged with the OR of status flags from many readout boards into a single prioritised global status code. The block also emulates the chip's pipeline address. A free-running counter, modulo `PIPE_LEN`, is latched at each accepted trigger and queued. The queued value is presented, oldest first, at the end of the matching emulated readout, so that readout boards can compare it with the address in their frame headers.

Top module: `occupancy_emulator`

## Requirements
- R1: Occupancy equals accepted triggers minus completed readouts. Capacity is 31 when `deconv_mode`=0 and 10 when `deconv_mode`=1. `busy` is high exactly while occupancy is at or above capacity.
- R2: A trigger that arrives while `busy` is high is not counted. It sets `error`, which stays high until reset.
- R3: Readouts run back to back while occupancy is nonzero. Each one lasts `readout_len` cycles, and 0 counts as 1. At the last cycle of a readout, `addr_strobe` pulses and occupancy drops by one on the next edge.
- R4: `warn` is high while occupancy >= `warn_level`. It stays high for `warn_hold` further cycles after that condition ends.
- R5: `ready` is high only when `busy`, `warn` and `error` are all low.
- R6: `global_status` encodes ERROR=4, OUT-OF-SYNCH=3, BUSY=2, WARNING=1 and READY=0, with priority in that order. It is built from the local flags ORed with every bit of `ext_error`, `ext_oos`, `ext_busy` and `ext_warn`. There is no local out-of-synch source.
- R7: The pipeline address is 0 in the first cycle after reset. It then advances by one every cycle and wraps from `PIPE_LEN`-1 to 0. Each accepted trigger captures the current value.
- R8: Captured addresses appear on `addr_out` in trigger order, each one valid in the cycle where `addr_strobe` is high.
- R9: After reset, occupancy is 0, `error` and `addr_strobe` are low, and with all external flags low `ready` is high and `global_status` is 0.
- R10: A trigger that fills the buffer makes `busy` visible in the cycle that directly follows its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | First-level trigger, one per cycle at most |
| deconv_mode | input | 1 | 1 = deconvolution (capacity 10), 0 = peak (capacity 31) |
| readout_len | input | LEN_W | Cycles per emulated readout (0 treated as 1) |
| warn_level | input | CW | Occupancy at which warning starts |
| warn_hold | input | HOLD_W | Extra cycles warning persists |
| ext_warn | input | NUM_BOARDS | Warning flags from readout boards |
| ext_busy | input | NUM_BOARDS | Busy flags from readout boards |
| ext_oos | input | NUM_BOARDS | Out-of-synch flags from readout boards |
| ext_error | input | NUM_BOARDS | Error flags from readout boards |
| occupancy | output | CW | Predicted pending events |
| ready | output | 1 | Local ready |
| warn | output | 1 | Local warning |
| busy | output | 1 | Local busy |
| error | output | 1 | Sticky local error |
| global_status | output | 3 | Prioritised merged status code |
| addr_strobe | output | 1 | End-of-readout pulse |
| addr_out | output | AW | Pipeline address of the event being completed |

## Verification
A wrong occupancy count shows at the `occupancy` port in the very next cycle. It then shifts the `busy` and `warn` edges, and the drain time of every later burst. A slip in the readout counter moves `addr_strobe` by whole cycles and is caught at the first completed readout. A broken address queue or pipeline counter shows as a wrong `addr_out` value at the first strobe after the faulty capture. Status faults appear the same cycle on `ready` and `global_status`, because both are checked against an independent model on every clock.

// File: rtl/occupancy_emulator.sv
module occupancy_emulator #(
  parameter int PIPE_LEN   = 192,
  parameter int PEAK_CAP   = 31,
  parameter int DECONV_CAP = 10,
  parameter int NUM_BOARDS = 4,
  parameter int LEN_W      = 8,
  parameter int HOLD_W     = 8,
  localparam int CW = $clog2(PEAK_CAP + 1),
  localparam int AW = $clog2(PIPE_LEN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig,
  input  logic                  deconv_mode,
  input  logic [LEN_W-1:0]      readout_len,
  input  logic [CW-1:0]         warn_level,
  input  logic [HOLD_W-1:0]     warn_hold,
  input  logic [NUM_BOARDS-1:0] ext_warn,
  input  logic [NUM_BOARDS-1:0] ext_busy,
  input  logic [NUM_BOARDS-1:0] ext_oos,
  input  logic [NUM_BOARDS-1:0] ext_error,
  output logic [CW-1:0]         occupancy,
  output logic                  ready,
  output logic                  warn,
  output logic                  busy,
  output logic                  error,
  output logic [2:0]            global_status,
  output logic                  addr_strobe,
  output logic [AW-1:0]         addr_out
);

  logic [CW-1:0]     occ, cap, wp, rp;
  logic [LEN_W-1:0]  rd_cnt, last;
  logic [AW-1:0]     ptr;
  logic [AW-1:0]     addr_q [2**CW];
  logic [HOLD_W-1:0] hold;
  logic              err_q, full, accept, done, near;

  assign cap    = deconv_mode ? CW'(DECONV_CAP) : CW'(PEAK_CAP);
  assign full   = occ >= cap;
  assign accept = trig && !full;
  assign last   = (readout_len == '0) ? '0 : readout_len - 1'b1;
  assign done   = (occ != '0) && (rd_cnt == last);
  assign near   = occ >= warn_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ    <= '0;
      rd_cnt <= '0;
      ptr    <= '0;
      wp     <= '0;
      rp     <= '0;
      hold   <= '0;
      err_q  <= 1'b0;
    end else begin
      occ    <= occ + CW'(accept) - CW'(done);
      rd_cnt <= (occ == '0 || done) ? '0 : rd_cnt + 1'b1;
      ptr    <= (ptr == AW'(PIPE_LEN - 1)) ? '0 : ptr + 1'b1;
      if (accept) wp <= wp + 1'b1;
      if (done) rp <= rp + 1'b1;
      if (trig && full) err_q <= 1'b1;
      if (near) hold <= warn_hold;
      else if (hold != '0) hold <= hold - 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (accept) addr_q[wp] <= ptr;

  assign occupancy   = occ;
  assign busy        = full;
  assign warn        = near || (hold != '0);
  assign error       = err_q;
  assign ready       = !full && !warn && !err_q;
  assign addr_strobe = done;
  assign addr_out    = addr_q[rp];

  always_comb begin
    if (err_q || |ext_error)     global_status = 3'd4;
    else if (|ext_oos)           global_status = 3'd3;
    else if (full || |ext_busy)  global_status = 3'd2;
    else if (warn || |ext_warn)  global_status = 3'd1;
    else                         global_status = 3'd0;
  end

endmodule

// File: rtl/occupancy_emulator_props.sv
module occupancy_emulator_props #(
  parameter int PEAK_CAP   = 31,
  parameter int DECONV_CAP = 10,
  localparam int CW = $clog2(PEAK_CAP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          deconv_mode,
  input logic [CW-1:0] occupancy,
  input logic          busy,
  input logic          warn,
  input logic          error,
  input logic          ready,
  input logic [2:0]    gstat,
  input logic          addr_strobe
);

  assert_cap_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= (deconv_mode ? CW'(DECONV_CAP) : CW'(PEAK_CAP)));

  assert_step_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (occupancy == $past(occupancy) || occupancy == $past(occupancy) + 1'b1
         || occupancy == $past(occupancy) - 1'b1));

  assert_full_trig_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig && busy |=> error);

  assert_full_trig_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig && busy && !addr_strobe |=> occupancy == $past(occupancy));

  assert_error_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  assert_strobe_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> occupancy != '0);

  assert_ready_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy && !warn && !error);

  assert_busy_reported_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> gstat >= 3'd2);

  assert_error_reported_R6: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> gstat == 3'd4);

endmodule

bind occupancy_emulator occupancy_emulator_props #(
  .PEAK_CAP(PEAK_CAP), .DECONV_CAP(DECONV_CAP)
) u_props (
  .clk(clk), .rst_n(rst_n), .trig(trig), .deconv_mode(deconv_mode),
  .occupancy(occupancy), .busy(busy), .warn(warn), .error(error),
  .ready(ready), .gstat(global_status), .addr_strobe(addr_strobe)
);

// File: tb/occupancy_emulator_test.sv
module occupancy_emulator_test;
  localparam int CLK_P = 10;
  localparam int PL = 192;
  localparam int NB = 4;

  logic clk = 0, rst_n = 0, trig = 0, deconv_mode = 0;
  logic [7:0] readout_len = 8'd4;
  logic [4:0] warn_level = 5'd28;
  logic [7:0] warn_hold = 8'd5;
  logic [NB-1:0] ext_warn = '0, ext_busy = '0, ext_oos = '0, ext_error = '0;
  logic [4:0] occupancy;
  logic ready, warn, busy, error, addr_strobe;
  logic [2:0] global_status;
  logic [7:0] addr_out;

  int total = 0, bad = 0, cycles = 0;
  int m_occ, m_rd, m_ptr, m_hold;
  bit m_err;
  int q[$];
  int ext_pct = 0;

  always #(CLK_P/2) clk = ~clk;

  occupancy_emulator uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .deconv_mode(deconv_mode),
    .readout_len(readout_len), .warn_level(warn_level), .warn_hold(warn_hold),
    .ext_warn(ext_warn), .ext_busy(ext_busy), .ext_oos(ext_oos), .ext_error(ext_error),
    .occupancy(occupancy), .ready(ready), .warn(warn), .busy(busy), .error(error),
    .global_status(global_status), .addr_strobe(addr_strobe), .addr_out(addr_out));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  function automatic int cap_of(input bit d);
    return d ? 10 : 31;
  endfunction

  function automatic int exp_gstat(input bit e, input bit b, input bit w);
    if (e || |ext_error) return 4;
    if (|ext_oos) return 3;
    if (b || |ext_busy) return 2;
    if (w || |ext_warn) return 1;
    return 0;
  endfunction

  task automatic do_reset(input bit mode, input int len, input int wl, input int wh);
    @(negedge clk);
    rst_n = 0; trig = 0;
    ext_warn = '0; ext_busy = '0; ext_oos = '0; ext_error = '0;
    deconv_mode = mode; readout_len = 8'(len); warn_level = 5'(wl); warn_hold = 8'(wh);
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_occ = 0; m_rd = 0; m_ptr = 0; m_hold = 0; m_err = 0; q.delete();
    #1;
    chk("R9 occupancy", occupancy, 0);
    chk("R9 error", error, 0);
    chk("R9 strobe", addr_strobe, 0);
    chk("R9 ready", ready, (wl > 0) ? 1 : 0);
    chk("R9 status", global_status, (wl > 0) ? 0 : 1);
  endtask

  task automatic cycle(input bit t);
    int cap, eff;
    bit full, done, near, w, acc;
    trig = t;
    if (ext_pct > 0)
      for (int i = 0; i < NB; i++) begin
        ext_warn[i]  = ($urandom_range(0, 99) < ext_pct);
        ext_busy[i]  = ($urandom_range(0, 99) < ext_pct);
        ext_oos[i]   = ($urandom_range(0, 199) < ext_pct);
        ext_error[i] = ($urandom_range(0, 399) < ext_pct);
      end
    #1;
    cap  = cap_of(deconv_mode);
    eff  = (readout_len == 0) ? 1 : int'(readout_len);
    full = m_occ >= cap;
    done = (m_occ != 0) && (m_rd == eff - 1);
    near = m_occ >= int'(warn_level);
    w    = near || (m_hold != 0);
    chk("R1 occupancy", occupancy, m_occ);
    chk("R10 busy", busy, full);
    chk("R4 warn", warn, w);
    chk("R2 error", error, m_err);
    chk("R5 ready", ready, !full && !w && !m_err);
    chk("R6 global", global_status, exp_gstat(m_err, full, w));
    chk("R3 strobe", addr_strobe, done);
    if (done) chk("R8 address", addr_out, q[0]);
    @(posedge clk);
    acc = t && !full;
    if (t && full) m_err = 1;
    if (acc) q.push_back(m_ptr);
    if (done) void'(q.pop_front());
    m_rd = (m_occ == 0 || done) ? 0 : m_rd + 1;
    m_occ = m_occ + int'(acc) - int'(done);
    if (near) m_hold = int'(warn_hold);
    else if (m_hold > 0) m_hold--;
    m_ptr = (m_ptr == PL - 1) ? 0 : m_ptr + 1;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 R2 R10: fill peak buffer, then trigger while full
    do_reset(0, 4, 28, 5);
    repeat (45) cycle(1);
    chk("R2 sticky error", error, 1);
    repeat (200) cycle(0);
    chk("R3 drained", occupancy, 0);
    // R3: readout length 0 behaves as 1
    do_reset(0, 0, 20, 0);
    repeat (30) cycle(1);
    repeat (10) cycle($urandom_range(0, 1));
    // R1: deconvolution capacity 10, slow readout
    do_reset(1, 50, 8, 12);
    repeat (15) cycle(1);
    chk("R1 deconv full", occupancy, 10);
    repeat (600) cycle(0);
    // R7: address wrap over several pipeline periods, sparse triggers
    do_reset(0, 3, 30, 0);
    for (int k = 0; k < 900; k++) cycle(k % 37 == 0);
    // R6: external statuses with empty local buffer
    do_reset(0, 5, 25, 2);
    ext_pct = 20;
    repeat (400) cycle($urandom_range(0, 9) == 0);
    ext_pct = 0;
    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      int mode, len, wl, pct;
      mode = ph % 2;
      len  = $urandom_range(0, 60);
      wl   = $urandom_range(1, cap_of(mode[0]));
      pct  = $urandom_range(3, 40);
      do_reset(mode[0], len, wl, $urandom_range(0, 20));
      ext_pct = (ph >= 6) ? 5 : 0;
      for (int k = 0; k < 2500; k++) cycle($urandom_range(0, 99) < pct);
      ext_pct = 0;
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule